// File: doc/BRIEF.md
# PC Card Byte-Lane Access Decoder

This block is the control logic of a linear flash card on a 16-bit PC Card host port. Each cycle it samples the host address, the two card enables, output enable, write enable, the attribute-space select and the write-protect switch. From these it registers three groups of controls:

- one chip select per byte lane for each fitted pair of 8-bit flash devices;
- the word address inside a device;
- steering controls that tell the data path which lanes to drive on reads, and which devices take a write and from which lane.

Devices are fitted in pairs. The even-byte device sits on the low lane and the odd-byte device on the high lane. Host bit A0 only matters for 8-bit access. The word address starts at host A1. The bits above it pick the pair. The card image repeats at the next power of two above the fitted density. The wait and battery-detect status outputs are tied inactive (high).

Top module: `pcc_byte_lane_dec`

## Requirements
- R1: While rst_ni is low, every chip select, lane control, write strobe, attr_sel_o and wp_o is 0. wait_no, bvd1_o and bvd2_o are 1.
- R2: With ce_lo_ni and ce_hi_ni both high (standby), no chip select, lane control, write strobe or attr_sel_o is asserted, whatever the other inputs are.
- R3: 8-bit access (ce_lo_ni low, ce_hi_ni high). A0=0 selects the even device and A0=1 the odd device. A read drives only the low lane, and rd_lo_odd_o equals A0. A write to the odd device sets wr_odd_lo_o=1, meaning its data comes from the low lane.
- R4: Word access (both enables low). Both devices of the pair are selected, and a read drives both lanes with rd_lo_odd_o=0. A0 has no effect.
- R5: Odd-only access (ce_lo_ni high, ce_hi_ni low). Only the odd device is selected, and a read drives only the high lane. wr_odd_lo_o is 0.
- R6: A read happens only with oe_ni low and we_ni high. we_ni low is a write even when oe_ni is also low, and then neither read lane control is asserted.
- R7: With attr_ni low, attr_sel_o is 1 for any read or write, and no flash chip select is asserted. Only an even-byte write strobe (wr_even_o) can occur; wr_odd_o stays 0. The write-protect switch does not block writes to this space.
- R8: arr_addr_o equals addr_i[DEV_AW:1]. The pair index is addr_i[WRAP_W-1:DEV_AW+1], where WRAP_W = DEV_AW+1+clog2(NUM_PAIRS). An index of NUM_PAIRS or above asserts no chip select. At most one bit of cs_lo_o and at most one bit of cs_hi_o is set.
- R9: Address bits at or above WRAP_W have no effect (the image wraps at 2^WRAP_W bytes).
- R10: With HAS_WP_SW=1, wp_o follows wp_sw_i, and a flash write while the switch reads 1 asserts no chip select and no write strobe. With HAS_WP_SW=0, wp_o is 0 and the switch is ignored.
- R11: wait_no, bvd1_o and bvd2_o are always 1.
- R12: Every decoded output reflects the inputs sampled at the previous rising clock edge. There is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host byte address |
| ce_lo_ni | input | 1 | Low-byte card enable, active low |
| ce_hi_ni | input | 1 | High-byte card enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| attr_ni | input | 1 | Attribute space select, active low |
| wp_sw_i | input | 1 | Write-protect switch, 1 = protected |
| cs_lo_o | output | NUM_PAIRS | Even-device chip select per pair |
| cs_hi_o | output | NUM_PAIRS | Odd-device chip select per pair |
| arr_addr_o | output | DEV_AW | Word address inside each device |
| attr_sel_o | output | 1 | Attribute memory access |
| rd_lo_en_o | output | 1 | Drive low data lane on read |
| rd_hi_en_o | output | 1 | Drive high data lane on read |
| rd_lo_odd_o | output | 1 | Low lane carries the odd byte |
| wr_even_o | output | 1 | Write strobe to even device / attribute store |
| wr_odd_o | output | 1 | Write strobe to odd device |
| wr_odd_lo_o | output | 1 | Odd-device write data taken from the low lane |
| wp_o | output | 1 | Write-protect status to host |
| wait_no | output | 1 | Wait status, held high |
| bvd1_o | output | 1 | Battery detect 1, held high |
| bvd2_o | output | 1 | Battery detect 2, held high |

## Verification
The hardest situation to reach is a flash write that the switch blocks while the address decodes to a fitted pair. A further case is that same write sent to attribute space, where the switch must not matter. Uniform random inputs hit the standby, idle and unfitted-pair codes too often to cover these well. Directed vectors therefore hold both enables low with a fitted pair index, then flip only the switch and attr_ni. Further directed vectors apply the same low address bits under different high bits, which exercises wrap-around. A second instance built without a switch confirms that the same writes are let through.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef struct packed {
    logic rd_lo;
    logic rd_hi;
    logic rd_lo_odd;
    logic wr_even;
    logic wr_odd;
    logic wr_odd_lo;
    logic flash_even;
    logic flash_odd;
    logic attr_sel;
  } lane_ctrl_t;
endpackage

// File: rtl/pcc_lane_decode.sv
module pcc_lane_decode
  import pcc_pkg::*;
(
  input  logic       ce_lo_ni,
  input  logic       ce_hi_ni,
  input  logic       a0_i,
  input  logic       oe_ni,
  input  logic       we_ni,
  input  logic       attr_ni,
  input  logic       wp_i,
  output lane_ctrl_t ctrl_o
);
  logic en, rd, wr, wr_ok, word, byte8, odd_only, need_even, need_odd, attr;

  always_comb begin
    en        = ~ce_lo_ni | ~ce_hi_ni;
    rd        = en & ~oe_ni & we_ni;
    wr        = en & ~we_ni;            // write wins over oe
    word      = ~ce_lo_ni & ~ce_hi_ni;
    byte8     = ~ce_lo_ni & ce_hi_ni;
    odd_only  = ce_lo_ni & ~ce_hi_ni;
    need_even = word | (byte8 & ~a0_i);
    need_odd  = word | (byte8 & a0_i) | odd_only;
    attr      = ~attr_ni;
    wr_ok     = wr & ~(wp_i & ~attr);  // protect covers array only

    ctrl_o.rd_lo      = rd & (word | byte8);
    ctrl_o.rd_hi      = rd & (word | odd_only);
    ctrl_o.rd_lo_odd  = rd & byte8 & a0_i;
    ctrl_o.wr_even    = wr_ok & need_even;
    ctrl_o.wr_odd     = wr_ok & need_odd & ~attr;
    ctrl_o.wr_odd_lo  = wr_ok & byte8 & a0_i & ~attr;
    ctrl_o.flash_even = ~attr & (rd | wr_ok) & need_even;
    ctrl_o.flash_odd  = ~attr & (rd | wr_ok) & need_odd;
    ctrl_o.attr_sel   = attr & (rd | wr);
  end
endmodule

// File: rtl/pcc_pair_select.sv
module pcc_pair_select #(
  parameter int NUM_PAIRS = 10,
  parameter int SEL_W     = 4
) (
  input  logic [SEL_W-1:0]     idx_i,
  output logic [NUM_PAIRS-1:0] hit_o
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign hit_o[p] = (idx_i == SEL_W'(p));
  end
endmodule

// File: rtl/pcc_byte_lane_dec.sv
module pcc_byte_lane_dec
  import pcc_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int NUM_PAIRS = 10,
  parameter int DEV_AW    = 17,
  parameter bit HAS_WP_SW = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 ce_lo_ni,
  input  logic                 ce_hi_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic                 attr_ni,
  input  logic                 wp_sw_i,
  output logic [NUM_PAIRS-1:0] cs_lo_o,
  output logic [NUM_PAIRS-1:0] cs_hi_o,
  output logic [DEV_AW-1:0]    arr_addr_o,
  output logic                 attr_sel_o,
  output logic                 rd_lo_en_o,
  output logic                 rd_hi_en_o,
  output logic                 rd_lo_odd_o,
  output logic                 wr_even_o,
  output logic                 wr_odd_o,
  output logic                 wr_odd_lo_o,
  output logic                 wp_o,
  output logic                 wait_no,
  output logic                 bvd1_o,
  output logic                 bvd2_o
);
  localparam int PAIR_W = $clog2(NUM_PAIRS);
  localparam int SEL_W  = (PAIR_W > 0) ? PAIR_W : 1;
  localparam int WRAP_W = DEV_AW + 1 + PAIR_W;

  logic [SEL_W-1:0]     pair_idx;
  logic [NUM_PAIRS-1:0] pair_hit;
  logic                 wp_eff;
  lane_ctrl_t           ctrl;

  if (PAIR_W > 0) begin : g_idx
    assign pair_idx = addr_i[WRAP_W-1:DEV_AW+1];
  end else begin : g_idx_one
    assign pair_idx = '0;
  end

  if (ADDR_W > WRAP_W) begin : g_wrap
    logic unused_hi;
    assign unused_hi = ^addr_i[ADDR_W-1:WRAP_W];
  end

  if (HAS_WP_SW) begin : g_wp
    assign wp_eff = wp_sw_i;
  end else begin : g_no_wp
    logic unused_wp;
    assign unused_wp = wp_sw_i;
    assign wp_eff    = 1'b0;
  end

  pcc_pair_select #(.NUM_PAIRS(NUM_PAIRS), .SEL_W(SEL_W)) u_pair (
    .idx_i (pair_idx),
    .hit_o (pair_hit)
  );

  pcc_lane_decode u_lane (
    .ce_lo_ni (ce_lo_ni),
    .ce_hi_ni (ce_hi_ni),
    .a0_i     (addr_i[0]),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .attr_ni  (attr_ni),
    .wp_i     (wp_eff),
    .ctrl_o   (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_lo_o     <= '0;
      cs_hi_o     <= '0;
      arr_addr_o  <= '0;
      attr_sel_o  <= 1'b0;
      rd_lo_en_o  <= 1'b0;
      rd_hi_en_o  <= 1'b0;
      rd_lo_odd_o <= 1'b0;
      wr_even_o   <= 1'b0;
      wr_odd_o    <= 1'b0;
      wr_odd_lo_o <= 1'b0;
      wp_o        <= 1'b0;
    end else begin
      cs_lo_o     <= pair_hit & {NUM_PAIRS{ctrl.flash_even}};
      cs_hi_o     <= pair_hit & {NUM_PAIRS{ctrl.flash_odd}};
      arr_addr_o  <= addr_i[DEV_AW:1];
      attr_sel_o  <= ctrl.attr_sel;
      rd_lo_en_o  <= ctrl.rd_lo;
      rd_hi_en_o  <= ctrl.rd_hi;
      rd_lo_odd_o <= ctrl.rd_lo_odd;
      wr_even_o   <= ctrl.wr_even;
      wr_odd_o    <= ctrl.wr_odd;
      wr_odd_lo_o <= ctrl.wr_odd_lo;
      wp_o        <= wp_eff;
    end
  end

  assign wait_no = 1'b1;
  assign bvd1_o  = 1'b1;
  assign bvd2_o  = 1'b1;

  // R2
  standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_lo_ni && ce_hi_ni) |=> (cs_lo_o == '0 && cs_hi_o == '0 && !rd_lo_en_o &&
                               !rd_hi_en_o && !wr_even_o && !wr_odd_o && !attr_sel_o));
  // R8
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_lo_o) && $onehot0(cs_hi_o));
  // R4
  word_both_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_lo_ni && !ce_hi_ni && !oe_ni && we_ni) |=> (rd_lo_en_o && rd_hi_en_o && !rd_lo_odd_o));
  // R6
  write_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> (!rd_lo_en_o && !rd_hi_en_o));
  // R7
  attr_no_flash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attr_ni |=> (cs_lo_o == '0 && cs_hi_o == '0 && !wr_odd_o));
  // R10
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_WP_SW && wp_sw_i && !we_ni && attr_ni) |=>
      (cs_lo_o == '0 && cs_hi_o == '0 && !wr_even_o && !wr_odd_o));
endmodule

// File: tb/pcc_byte_lane_dec_tb.sv
module pcc_byte_lane_dec_tb;
  localparam int ADDR_W = 26, NP = 10, DAW = 17;
  localparam int WRAP_W = DAW + 1 + $clog2(NP);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic ce_lo_n = 1, ce_hi_n = 1, oe_n = 1, we_n = 1, attr_n = 1, wp = 0;
  logic [NP-1:0] cs_lo, cs_hi, cs_lo2, cs_hi2;
  logic [DAW-1:0] arr, arr2;
  logic attr_sel, rd_lo, rd_hi, rd_odd, wr_e, wr_o, wr_ol, wp_out, wait_n, bvd1, bvd2;
  logic attr_sel2, rd_lo2, rd_hi2, rd_odd2, wr_e2, wr_o2, wr_ol2, wp_out2, wait_n2, bvd12, bvd22;
  int n_cmp = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcc_byte_lane_dec #(.ADDR_W(ADDR_W), .NUM_PAIRS(NP), .DEV_AW(DAW), .HAS_WP_SW(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .ce_lo_ni(ce_lo_n), .ce_hi_ni(ce_hi_n),
    .oe_ni(oe_n), .we_ni(we_n), .attr_ni(attr_n), .wp_sw_i(wp),
    .cs_lo_o(cs_lo), .cs_hi_o(cs_hi), .arr_addr_o(arr), .attr_sel_o(attr_sel),
    .rd_lo_en_o(rd_lo), .rd_hi_en_o(rd_hi), .rd_lo_odd_o(rd_odd), .wr_even_o(wr_e),
    .wr_odd_o(wr_o), .wr_odd_lo_o(wr_ol), .wp_o(wp_out), .wait_no(wait_n),
    .bvd1_o(bvd1), .bvd2_o(bvd2));

  pcc_byte_lane_dec #(.ADDR_W(ADDR_W), .NUM_PAIRS(NP), .DEV_AW(DAW), .HAS_WP_SW(1'b0)) u_dut_nowp (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .ce_lo_ni(ce_lo_n), .ce_hi_ni(ce_hi_n),
    .oe_ni(oe_n), .we_ni(we_n), .attr_ni(attr_n), .wp_sw_i(wp),
    .cs_lo_o(cs_lo2), .cs_hi_o(cs_hi2), .arr_addr_o(arr2), .attr_sel_o(attr_sel2),
    .rd_lo_en_o(rd_lo2), .rd_hi_en_o(rd_hi2), .rd_lo_odd_o(rd_odd2), .wr_even_o(wr_e2),
    .wr_odd_o(wr_o2), .wr_odd_lo_o(wr_ol2), .wp_o(wp_out2), .wait_no(wait_n2),
    .bvd1_o(bvd12), .bvd2_o(bvd22));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // packed expectation: {cs_lo, cs_hi, attr_sel, rd_lo, rd_hi, rd_odd, wr_e, wr_o, wr_ol}
  function automatic logic [2*NP+6:0] model(input logic [ADDR_W-1:0] a, input logic cl, ch,
                                            input logic o, w, r, p, input bit has_wp);
    logic en, rd, wr, at, blk, wok, word, b8, od, ne, no;
    int pair;
    logic [NP-1:0] hl, hh;
    en = !cl || !ch; at = !r;
    rd = en && !o && w; wr = en && !w;
    blk = has_wp && p && !at; wok = wr && !blk;
    word = !cl && !ch; b8 = !cl && ch; od = cl && !ch;
    ne = word || (b8 && !a[0]); no = word || (b8 && a[0]) || od;
    pair = int'((a % (64'd1 << WRAP_W)) >> (DAW + 1));
    hl = '0; hh = '0;
    if (pair < NP && !at && (rd || wok)) begin
      if (ne) hl[pair] = 1'b1;
      if (no) hh[pair] = 1'b1;
    end
    return {hl, hh, at && (rd || wr), rd && (word || b8), rd && (word || od), rd && b8 && a[0],
            wok && ne, wok && no && !at, wok && b8 && a[0] && !at};
  endfunction

  function automatic string tag_of(input logic cl, ch, w, r, p);
    if (cl && ch) return "R2";
    if (!r) return "R7";
    if (!w && p) return "R10";
    if (!cl && !ch) return "R4";
    if (!cl) return "R3";
    return "R5";
  endfunction

  task automatic apply(input logic [ADDR_W-1:0] a, input logic cl, ch, o, w, r, p, input string tag);
    logic [2*NP+6:0] e, e2;
    @(negedge clk);
    addr = a; ce_lo_n = cl; ce_hi_n = ch; oe_n = o; we_n = w; attr_n = r; wp = p;
    e  = model(a, cl, ch, o, w, r, p, 1'b1);
    e2 = model(a, cl, ch, o, w, r, p, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(tag, {cs_lo, cs_hi, attr_sel, rd_lo, rd_hi, rd_odd, wr_e, wr_o, wr_ol}, e);
    chk("R8 arr", arr, a[DAW:1]);
    chk("R10 wp", wp_out, p);
    chk("R10 nowp", {wp_out2, cs_lo2, cs_hi2, attr_sel2, rd_lo2, rd_hi2, rd_odd2, wr_e2, wr_o2, wr_ol2},
        {1'b0, e2});
    chk("R11", {wait_n, bvd1, bvd2}, 3'b111);
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int pair, input int word, input bit a0);
    return ADDR_W'((longint'(pair) << (DAW + 1)) | (longint'(word) << 1) | a0);
  endfunction

  initial begin
    void'($urandom(32'h5eed_0c4d));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {cs_lo, cs_hi, attr_sel, rd_lo, rd_hi, rd_odd, wr_e, wr_o, wr_ol, wp_out}, 0);
    chk("R1 status", {wait_n, bvd1, bvd2}, 3'b111);
    rst_ni = 1'b1;

    // R3 byte reads, even and odd
    apply(mk(2, 5, 0), 0, 1, 0, 1, 1, 0, "R3 even rd");
    apply(mk(2, 5, 1), 0, 1, 0, 1, 1, 0, "R3 odd rd");
    apply(mk(3, 7, 1), 0, 1, 1, 0, 1, 0, "R3 odd wr low lane");
    // R4 A0 ignored
    apply(mk(9, 1, 0), 0, 0, 0, 1, 1, 0, "R4 a0=0");
    apply(mk(9, 1, 1), 0, 0, 0, 1, 1, 0, "R4 a0=1");
    // R5
    apply(mk(0, 3, 0), 1, 0, 0, 1, 1, 0, "R5 rd");
    apply(mk(0, 3, 1), 1, 0, 1, 0, 1, 0, "R5 wr");
    // R6 oe and we both low
    apply(mk(4, 9, 0), 0, 0, 0, 0, 1, 0, "R6 oe+we");
    apply(mk(4, 9, 0), 0, 0, 1, 1, 1, 0, "R6 idle");
    // R2 standby with write request
    apply(mk(1, 2, 0), 1, 1, 0, 0, 1, 0, "R2");
    // R10 blocked flash write vs attribute write under protection
    apply(mk(5, 4, 0), 0, 0, 1, 0, 1, 1, "R10 blocked");
    apply(mk(5, 4, 0), 0, 0, 1, 0, 0, 1, "R7 attr wr wp");
    apply(mk(5, 4, 1), 0, 1, 0, 1, 0, 0, "R7 attr odd rd");
    // R8 unfitted pairs
    apply(mk(10, 0, 0), 0, 0, 0, 1, 1, 0, "R8 pair10");
    apply(mk(15, 0, 0), 0, 0, 0, 1, 1, 0, "R8 pair15");
    // R9 wrap: high bits ignored
    apply(mk(6, 11, 0) | ADDR_W'(1 << WRAP_W), 0, 0, 0, 1, 1, 0, "R9 wrap");
    apply(mk(6, 11, 0) | {{(ADDR_W-WRAP_W){1'b1}}, {WRAP_W{1'b0}}}, 0, 0, 1, 0, 1, 0, "R9 wrap wr");
    // R12 latency: output unchanged before the edge
    @(negedge clk);
    addr = mk(7, 0, 0); ce_lo_n = 0; ce_hi_n = 0; oe_n = 0; we_n = 1; attr_n = 1; wp = 0;
    #2 chk("R12 before edge", {rd_lo, rd_hi}, 2'b00);
    @(posedge clk); #2 chk("R12 after edge", {rd_lo, rd_hi, cs_lo[7]}, 3'b111);

    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      logic [5:0] c;
      a = ADDR_W'({$urandom, $urandom});
      c = 6'($urandom);
      apply(a, c[0], c[1], c[2], c[3], c[4] | c[5], c[5] & c[2],
            tag_of(c[0], c[1], c[3], c[4] | c[5], c[5] & c[2]));
    end

    @(negedge clk); rst_ni = 1'b0; #2;
    chk("R1 async", {cs_lo, cs_hi, rd_lo, rd_hi, wr_e, wr_o}, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule